// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous host port to an external asynchronous static RAM that is one byte wide and has 19 address lines (524,288 locations). The host offers a request with a direction bit, an address and a write byte. The controller accepts it when `req_ready` is high. It then drives the memory's active-low select, output-enable and write strobes, together with the address and a data bus that is split into output, output-enable and input halves so that the pad can sit at the chip edge. For a read it returns the captured byte with a single-cycle `rsp_done` pulse. For a write the same pulse marks completion.

Every memory timing limit is turned into a whole number of clock cycles by rounding up against `CLK_PERIOD_NS`. The read window, the write strobe width, the write cycle length and the bus release time after a read are each timed on their own. `FAST_GRADE` chooses between the 85 ns and the 70 ns limit sets. All pin outputs come straight from flops.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all three strobes are high, `sram_dq_oe` and `rsp_done` are low, and `req_ready` is high.
- R2: The strobe patterns are: idle means select high; read means select low, output-enable low and write high; write means select low, write low and output-enable high. Output-enable and write are never low together, and select returns high between any two accesses.
- R3: A read holds select, output-enable and the address for RD cycles, where RD is the larger of ceil(access time / period) and ceil(output-enable access / period). The byte on `sram_dq_i` is captured at the last of those edges. `rsp_done` rises in the following cycle, RD+1 cycles after the accepting edge, and `rsp_rdata` then shows the byte stored at the address.
- R4: A write asserts select for one setup cycle and then holds write low for WP cycles. WP is the largest of ceil(write pulse), ceil(address-to-end) - 1, ceil(select-to-end) - 1 and ceil(data setup). `sram_dq_oe` is high exactly while write is low, and the write byte is on `sram_dq_o` for that whole time.
- R5: After write rises, select stays low for WH more cycles, where WH = max(1, ceil(write cycle) - 1 - WP). A write therefore keeps select low for 1+WP+WH cycles, which covers the write cycle time. `rsp_done` appears 2+WP+WH cycles after the accepting edge.
- R6: The address pins never change while select is low. In particular they do not change while write is low.
- R7: After a read, `req_ready` stays low for TURN cycles, starting with the `rsp_done` cycle. TURN = ceil(max(output-enable float, select float) / period). So no data is driven while the memory may still be releasing the bus.
- R8: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low during every access, and requests offered then leave the pins and the memory unchanged. After a write, `req_ready` is already high in the `rsp_done` cycle.
- R9: With `FAST_GRADE` = 1 the 70 ns set applies. At a 4 ns period this gives RD = 18, WP = 14 and WH = 3. The 85 ns set gives RD = 22, WP = 17, WH = 4 and TURN = 9.
- R10: `rsp_done` lasts exactly one cycle. `rsp_rdata` holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pad |
| sram_dq_i | input | DATA_W | Data from the memory |

## Verification
The hardest case to reach is a write that follows a read as closely as the host allows, because only then could the controller drive the bus while the memory is still releasing it. The bench's memory model keeps driving for the release window after every read and flags any overlap with `sram_dq_oe`. Random mixes of reads and writes over a small address pool make read-then-write pairs frequent, and a directed pair forces one. The model also returns a wrong byte until the full access time has passed, so a capture that comes one cycle early is seen at `rsp_rdata`.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WHLD
  } asram_st_e;

  // nanosecond limits of one speed grade
  typedef struct packed {
    int unsigned rd_cycle;
    int unsigned addr_acc;
    int unsigned oe_acc;
    int unsigned wr_cycle;
    int unsigned we_width;
    int unsigned addr_to_end;
    int unsigned ce_to_end;
    int unsigned data_to_end;
    int unsigned oe_float;
    int unsigned ce_float;
  } asram_ns_t;

  // derived cycle counts
  typedef struct packed {
    int unsigned rd;
    int unsigned wp;
    int unsigned wh;
    int unsigned turn;
  } asram_cyc_t;

  localparam asram_ns_t SLOW_NS = '{rd_cycle: 85, addr_acc: 85, oe_acc: 40,
                                    wr_cycle: 85, we_width: 60, addr_to_end: 70,
                                    ce_to_end: 70, data_to_end: 35,
                                    oe_float: 30, ce_float: 35};
  localparam asram_ns_t FAST_NS = '{rd_cycle: 70, addr_acc: 70, oe_acc: 40,
                                    wr_cycle: 70, we_width: 50, addr_to_end: 60,
                                    ce_to_end: 60, data_to_end: 30,
                                    oe_float: 25, ce_float: 25};

  function automatic int unsigned up_div(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // the setup cycle before the strobe already counts toward a limit
  function automatic int unsigned minus_setup(int unsigned c);
    return (c > 1) ? c - 1 : 1;
  endfunction

  function automatic asram_cyc_t asram_cycles(bit fast, int unsigned per);
    asram_ns_t  t;
    asram_cyc_t c;
    int unsigned wc;
    int unsigned used;
    t      = fast ? FAST_NS : SLOW_NS;
    c.rd   = umax(umax(up_div(t.rd_cycle, per), up_div(t.addr_acc, per)),
                  umax(up_div(t.oe_acc, per), 1));
    c.wp   = umax(umax(up_div(t.we_width, per), up_div(t.data_to_end, per)),
                  umax(minus_setup(up_div(t.addr_to_end, per)),
                       minus_setup(up_div(t.ce_to_end, per))));
    wc     = up_div(t.wr_cycle, per);
    used   = 1 + c.wp;
    c.wh   = (wc > used + 1) ? wc - used : 1;
    c.turn = umax(1, up_div(umax(t.oe_float, t.ce_float), per));
    return c;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned WH_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             wait_zero,
  input  logic             turn_zero,
  output logic             ready,
  output logic             accept,
  output logic             wait_load,
  output logic [CNT_W-1:0] wait_val,
  output logic             rd_end,
  output logic             we_on,
  output logic             we_off,
  output logic             wr_end
);
  asram_st_e st, st_nx;

  always_comb begin
    ready     = (st == ST_IDLE) && turn_zero;
    accept    = ready && req_valid;
    rd_end    = (st == ST_RD)   && wait_zero;
    we_on     = (st == ST_WSET);
    we_off    = (st == ST_WPUL) && wait_zero;
    wr_end    = (st == ST_WHLD) && wait_zero;
    wait_load = 1'b0;
    wait_val  = '0;
    st_nx     = st;
    case (st)
      ST_IDLE: if (accept) begin
        if (req_write) st_nx = ST_WSET;
        else begin
          st_nx     = ST_RD;
          wait_load = 1'b1;
          wait_val  = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD:   if (wait_zero) st_nx = ST_IDLE;
      ST_WSET: begin
        st_nx     = ST_WPUL;
        wait_load = 1'b1;
        wait_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WPUL: if (wait_zero) begin
        st_nx     = ST_WHLD;
        wait_load = 1'b1;
        wait_val  = CNT_W'(WH_CYC - 1);
      end
      ST_WHLD: if (wait_zero) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  // R7: bus release window follows every read
  a_r7_hold_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_end |=> !ready);
  // R8: nothing is taken outside idle
  a_r8_accept_idle: assert property (@(posedge clk) disable iff (rst)
    accept |=> (st != ST_IDLE));
endmodule

// File: rtl/asram_pads.sv
module asram_pads #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_end,
  input  logic              we_on,
  input  logic              we_off,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PW_W = $clog2(WP_CYC + 2) + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_o  <= '0;
      dq_oe <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= rd_end | wr_end;
      if (accept) begin
        addr <= req_addr;
        ce_n <= 1'b0;
        oe_n <= req_write;
        dq_o <= req_wdata;
      end
      if (we_on) begin
        we_n  <= 1'b0;
        dq_oe <= 1'b1;
      end
      if (we_off) begin
        we_n  <= 1'b1;
        dq_oe <= 1'b0;
      end
      if (rd_end) begin
        rdata <= dq_i;
        ce_n  <= 1'b1;
        oe_n  <= 1'b1;
      end
      if (wr_end) ce_n <= 1'b1;
    end
  end

  // length of the current write strobe, for the pulse check
  logic [PW_W-1:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst)        we_low_cnt <= '0;
    else if (!we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else            we_low_cnt <= '0;
  end

  a_r2_no_oe_we_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));
  a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);
  a_r4_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_low_cnt == PW_W'(WP_CYC)));
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter bit          FAST_GRADE    = 1'b0,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam asram_cyc_t  CYC      = asram_cycles(FAST_GRADE, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC   = CYC.rd;
  localparam int unsigned WP_CYC   = CYC.wp;
  localparam int unsigned WH_CYC   = CYC.wh;
  localparam int unsigned TURN_CYC = CYC.turn;
  localparam int unsigned CNT_W    = $clog2(RD_CYC + WP_CYC + WH_CYC + TURN_CYC + 2);

  logic             accept, wait_load, wait_zero, turn_zero;
  logic [CNT_W-1:0] wait_val;
  logic             rd_end, we_on, we_off, wr_end;

  asram_fsm #(
    .CNT_W (CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .WH_CYC(WH_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .wait_zero(wait_zero), .turn_zero(turn_zero), .ready(req_ready),
    .accept(accept), .wait_load(wait_load), .wait_val(wait_val),
    .rd_end(rd_end), .we_on(we_on), .we_off(we_off), .wr_end(wr_end)
  );

  asram_cnt #(.W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val), .zero(wait_zero)
  );

  asram_cnt #(.W(CNT_W)) u_turn (
    .clk(clk), .rst(rst), .load(rd_end), .load_val(CNT_W'(TURN_CYC)), .zero(turn_zero)
  );

  asram_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_CYC(WP_CYC)) u_pads (
    .clk(clk), .rst(rst), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_end(rd_end),
    .we_on(we_on), .we_off(we_off), .wr_end(wr_end), .dq_i(sram_dq_i),
    .addr(sram_addr), .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .dq_o(sram_dq_o), .dq_oe(sram_dq_oe), .done(rsp_done), .rdata(rsp_rdata)
  );

  // R8: ready only with the memory deselected and the pad released
  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && !sram_dq_oe));
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int P = 4;

  function automatic int cdiv(int ns);
    return (ns + P - 1) / P;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(cdiv(85), cdiv(40));
  localparam int E_WP   = mx(mx(cdiv(60), cdiv(70) - 1), cdiv(35));
  localparam int E_WH   = mx(1, cdiv(85) - 1 - E_WP);
  localparam int E_TURN = cdiv(35);
  localparam int F_RD   = mx(cdiv(70), cdiv(40));
  localparam int F_WP   = mx(mx(cdiv(50), cdiv(60) - 1), cdiv(30));
  localparam int F_WH   = mx(1, cdiv(70) - 1 - F_WP);

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst = 1'b1;

  logic        req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_done;
  logic [18:0] req_addr = '0, sram_addr;
  logic [7:0]  req_wdata = '0, rsp_rdata, sram_dq_o, sram_dq_i;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;

  asram_ctrl #(.FAST_GRADE(1'b0), .CLK_PERIOD_NS(P)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  logic        f_valid = 1'b0, f_write = 1'b0, f_ready, f_done;
  logic [18:0] f_addr = 19'h00042, f_addr_o;
  logic [7:0]  f_wdata = 8'h99, f_rdata, f_dqo;
  logic [7:0]  f_dqi = 8'h3C;
  logic        f_ce, f_oe, f_we, f_dqoe;

  asram_ctrl #(.FAST_GRADE(1'b1), .CLK_PERIOD_NS(P)) uut_fast (
    .clk(clk), .rst(rst), .req_valid(f_valid), .req_ready(f_ready),
    .req_write(f_write), .req_addr(f_addr), .req_wdata(f_wdata),
    .rsp_done(f_done), .rsp_rdata(f_rdata), .sram_addr(f_addr_o),
    .sram_ce_n(f_ce), .sram_oe_n(f_oe), .sram_we_n(f_we),
    .sram_dq_o(f_dqo), .sram_dq_oe(f_dqoe), .sram_dq_i(f_dqi)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(logic [18:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5A;
  endfunction

  // ---------------- memory model ----------------
  logic [7:0]  mem  [int];
  logic [7:0]  refm [int];
  logic        m_drive = 1'b0;
  logic [7:0]  m_val = '0;
  int          rd_cnt = 0, hz_cnt = 0, we_cnt = 0, ce_cnt = 0;
  logic        prev_ce_n = 1'b1, prev_we_n = 1'b1, prev_rd = 1'b0, was_wr = 1'b0;
  logic [18:0] prev_addr = '0, w_addr = '0;
  logic [7:0]  w_data = '0;

  assign sram_dq_i = m_drive ? m_val : 8'h00;

  always @(negedge clk) begin
    logic rd_now;
    logic [7:0] stored;
    if (!rst) begin
      rd_now = !sram_ce_n && !sram_oe_n && sram_we_n;
      stored = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : dflt(sram_addr);
      if (!sram_ce_n && !prev_ce_n && sram_addr != prev_addr)
        chk(1'b0, "R6", "address moved during access", 32'(sram_addr), 32'(prev_addr));
      if (!sram_we_n && !sram_oe_n)
        chk(1'b0, "R2", "oe and we both low", 0, 1);
      if (sram_dq_oe != !sram_we_n)
        chk(1'b0, "R4", "drive enable not matching write strobe", 32'(sram_dq_oe), 32'(!sram_we_n));
      if (!sram_ce_n) ce_cnt++;
      if (rd_now) begin
        rd_cnt++;
        hz_cnt  = E_TURN;
        m_drive = 1'b1;
        m_val   = (rd_cnt >= E_RD) ? stored : ~stored;
      end else if (hz_cnt > 0) begin
        hz_cnt--;
        m_drive = 1'b1;
        m_val   = 8'hC3;
      end else begin
        m_drive = 1'b0;
      end
      if (prev_rd && !rd_now) begin
        chk(rd_cnt == E_RD, "R3", "read strobe length", 32'(rd_cnt), 32'(E_RD));
        rd_cnt = 0;
      end
      if (sram_dq_oe && m_drive)
        chk(1'b0, "R7", "bus contention after read", 1, 0);
      if (!sram_we_n) begin
        we_cnt++;
        was_wr = 1'b1;
        w_addr = sram_addr;
        w_data = sram_dq_o;
      end
      if (sram_we_n && !prev_we_n) begin
        mem[int'(w_addr)] = w_data;
        chk(we_cnt == E_WP, "R4", "write strobe length", 32'(we_cnt), 32'(E_WP));
        we_cnt = 0;
      end
      if (sram_ce_n && !prev_ce_n) begin
        if (was_wr) begin
          chk(ce_cnt == 1 + E_WP + E_WH, "R5", "select low during write",
              32'(ce_cnt), 32'(1 + E_WP + E_WH));
          chk(ce_cnt * P >= 85, "R5", "write cycle ns", 32'(ce_cnt * P), 85);
        end
        was_wr = 1'b0;
        ce_cnt = 0;
      end
      prev_rd   = rd_now;
      prev_ce_n = sram_ce_n;
      prev_we_n = sram_we_n;
      prev_addr = sram_addr;
    end
  end

  // ---------------- host tasks ----------------
  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic finish_op(input bit wr, input logic [18:0] a, input logic [7:0] d, input int k0);
    int k;
    int n;
    logic [7:0] exp;
    k = k0;
    do begin @(negedge clk); k++; end while (!rsp_done && k < 300);
    if (wr) begin
      refm[int'(a)] = d;
      chk(k == 2 + E_WP + E_WH, "R5", "write done latency", 32'(k), 32'(2 + E_WP + E_WH));
      chk(req_ready == 1'b1, "R8", "ready in write done cycle", 32'(req_ready), 1);
    end else begin
      exp = refm.exists(int'(a)) ? refm[int'(a)] : dflt(a);
      chk(rsp_rdata == exp, "R3", "read data", 32'(rsp_rdata), 32'(exp));
      chk(k == E_RD + 1, "R3", "read done latency", 32'(k), 32'(E_RD + 1));
      n = 0;
      while (!req_ready && n < 100) begin n++; @(negedge clk); end
      chk(n == E_TURN, "R7", "ready low after read", 32'(n), 32'(E_TURN));
      chk(!rsp_done, "R10", "done single cycle", 32'(rsp_done), 0);
      chk(rsp_rdata == exp, "R10", "read data held", 32'(rsp_rdata), 32'(exp));
    end
  endtask

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    issue(wr, a, d);
    finish_op(wr, a, d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [18:0] pool [8];
    int k;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1", "strobes in reset", 
        {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!sram_dq_oe && !rsp_done, "R1", "drive and done in reset", 32'(sram_dq_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && sram_ce_n && sram_we_n && sram_oe_n, "R1", "idle after reset", 32'(req_ready), 1);

    // R3 / R2 basic and boundary addresses
    do_op(1'b1, 19'h00000, 8'h11);
    do_op(1'b0, 19'h00000, 8'h00);
    do_op(1'b1, 19'h7FFFF, 8'hEE);
    do_op(1'b0, 19'h7FFFF, 8'h00);
    do_op(1'b0, 19'h12345, 8'h00);
    // R7: write right after a read
    do_op(1'b0, 19'h00000, 8'h00);
    do_op(1'b1, 19'h00001, 8'hA7);
    do_op(1'b0, 19'h00001, 8'h00);
    // back-to-back writes
    do_op(1'b1, 19'h00100, 8'h01);
    do_op(1'b1, 19'h00101, 8'h02);
    do_op(1'b0, 19'h00100, 8'h00);

    // R8: request offered while busy is ignored
    issue(1'b0, 19'h00100, 8'h00);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h0BEEF; req_wdata = 8'h77;
    repeat (3) @(negedge clk);
    chk(sram_addr == 19'h00100 && !req_ready, "R8", "busy request not taken",
        32'(sram_addr), 32'h100);
    req_valid = 1'b0;
    finish_op(1'b0, 19'h00100, 8'h00, 6);
    do_op(1'b0, 19'h0BEEF, 8'h00);

    // random mix
    pool[0] = 19'h00000;
    pool[1] = 19'h7FFFF;
    for (int i = 2; i < 8; i++) pool[i] = 19'($urandom());
    for (int i = 0; i < 200; i++) begin
      logic [18:0] a;
      a = pool[$urandom_range(0, 7)];
      do_op(1'($urandom_range(0, 1)), a, 8'($urandom()));
    end

    // R9: faster grade
    @(negedge clk);
    f_valid = 1'b1; f_write = 1'b1;
    @(posedge clk);
    #1 f_valid = 1'b0;
    k = 0;
    do begin @(negedge clk); if (!f_we) k++; end while (!f_done);
    chk(k == F_WP, "R9", "fast write strobe", 32'(k), 32'(F_WP));
    @(negedge clk);
    f_valid = 1'b1; f_write = 1'b0;
    @(posedge clk);
    #1 f_valid = 1'b0;
    k = 0;
    do begin @(negedge clk); if (!f_ce) k++; end while (!f_done);
    chk(k == F_RD, "R9", "fast read window", 32'(k), 32'(F_RD));
    chk(f_rdata == 8'h3C, "R9", "fast read data", 32'(f_rdata), 32'h3C);
    chk(F_WH == 3, "R9", "fast write recovery count", 32'(F_WH), 3);

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule